// File: doc/BRIEF.md
# Per-Pin Debounce Filter Bank

This block cleans up the slow interrupt pins of a chip before they reach the interrupt controller. Every pin is first brought into the clock domain by a two-flop synchroniser. The lowest `NUM_FILT` pins also get a glitch filter. While a filter is active, its output takes a new level only after the synchronised input has held that level for a whole chosen period. Any return to the old level before that restarts the wait.

A filter is active only when three things hold: the pin is enabled in its control byte, the interrupt controller marks the pin as level-sensitive, and the chosen period is not zero. In every other case the synchronised level passes straight through.

Each pin selects its period from a fixed non-linear table, measured in time units. One shared prescaler produces a tick every `TICK_DIV` clocks. The table value is shifted right by `SCALE_SHIFT` to give the number of ticks. Software reaches the control bytes through a 32-bit port that has three windows: a read-only view, a write-one-to-set window and a write-one-to-clear window. Setting the one-shot reload bit restarts a pin's filter at once.

Top module: `pin_debounce_bank`

## Requirements
- R1: Pin n's control byte sits in word n/4 at bits 8*(n%4)+7 down to 8*(n%4). Within the byte, bit 0 is the enable and bits 7:4 are the period select. Bits 3:1 always read 0. A read at 0x500 + 4*word returns the word; reads at any other address return 0.
- R2: Writing to 0x600 + 4*word sets each enable or select bit that is written as 1. Writing to 0x700 + 4*word clears each such bit. Writes to the read-only view at 0x500 change nothing.
- R3: For pins at or above NUM_FILT, the control byte reads 0, writes to it are ignored, and the output equals the raw input two clock edges later.
- R4: When a pin is disabled, or is not marked level-sensitive, its output equals its raw input two clock edges later.
- R5: Select values 0 to 6 give 500, 1000, 16000, 32000, 64000, 128000 and 256000 units. Any value above 6 gives 256000. The period in ticks is units >> SCALE_SHIFT, and one tick is TICK_DIV clocks.
- R6: With an active filter of P ticks, an input change reaches the output after between (P-1)*TICK_DIV+3 and P*TICK_DIV+2 clock edges.
- R7: An input pulse shorter than the period never reaches the output. An input that goes back to the output level restarts the full period.
- R8: Writing 1 to bit 1 of a pin's byte in the set window clears that pin's counter and loads its output from the synchronised input at the same clock edge. The bit is never stored and reads as 0.
- R9: A select whose tick count comes out as 0 turns the filter off, so the pin passes straight through.
- R10: After reset every control byte reads 0 and every output follows its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address of the register port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| pin_raw | input | NUM_PINS | Asynchronous pin levels |
| pin_level_mode | input | NUM_PINS | 1 marks a pin as level-sensitive |
| pin_filt | output | NUM_PINS | Filtered pin levels |

## Verification
Some rules are checked by assertions on every cycle:
- an active filter's output moves only on a prescaler tick;
- a matching input keeps the counter at zero;
- an idle filter copies its input;
- a reload lands on the next edge;
- unfiltered pins follow the first synchroniser stage;
- ticks never come on two edges in a row.

Other behaviour can only be shown by the bench's scenarios:
- latency windows for every table entry;
- glitch rejection and restart of the count;
- the masking done by the set and clear windows;
- the zero-period pass-through, which needs a second instance with a larger shift.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam int unsigned SEL_W         = 4;
    localparam int unsigned LONGEST_UNITS = 256000;

    localparam logic [3:0] REGION_VIEW = 4'h5;
    localparam logic [3:0] REGION_SET  = 4'h6;
    localparam logic [3:0] REGION_CLR  = 4'h7;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
    } pin_cfg_t;

    // Non-linear period table in time units; out-of-range selects saturate.
    function automatic logic [31:0] period_units(input logic [SEL_W-1:0] sel);
        case (sel)
            4'd0:    period_units = 32'd500;
            4'd1:    period_units = 32'd1000;
            4'd2:    period_units = 32'd16000;
            4'd3:    period_units = 32'd32000;
            4'd4:    period_units = 32'd64000;
            4'd5:    period_units = 32'd128000;
            default: period_units = 32'(LONGEST_UNITS);
        endcase
    endfunction

endpackage

// File: rtl/dbf_tick_gen.sv
module dbf_tick_gen #(
    parameter int unsigned TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned W = $clog2(TICK_DIV);

            typedef struct packed {
                logic [W-1:0] cnt;
            } tick_state_t;

            tick_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (st_q.cnt == W'(TICK_DIV - 1)) st_d.cnt = '0;
                else                              st_d.cnt = st_q.cnt + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick = (st_q.cnt == W'(TICK_DIV - 1));

            // R5: ticks are spaced by the divider, never back to back
            p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dbf_ctrl_regs.sv
module dbf_ctrl_regs
    import dbf_pkg::*;
#(
    parameter int unsigned NUM_FILT = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [11:0]              bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output pin_cfg_t [NUM_FILT-1:0]  cfg_o,
    output logic [NUM_FILT-1:0]      reload_o
);

    localparam int unsigned WORD_W = 6;

    typedef struct packed {
        pin_cfg_t [NUM_FILT-1:0] cfg;
    } reg_state_t;

    reg_state_t          st_d, st_q;
    logic [WORD_W-1:0]   word_sel;
    logic                aligned;
    logic                wr_set, wr_clr, rd_view;
    logic [NUM_FILT-1:0] reload;
    logic [31:0]         rdata;
    logic                unused_wbits;

    assign word_sel = bus_addr[7:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign wr_set   = bus_we && aligned && (bus_addr[11:8] == REGION_SET);
    assign wr_clr   = bus_we && aligned && (bus_addr[11:8] == REGION_CLR);
    assign rd_view  = aligned && (bus_addr[11:8] == REGION_VIEW);
    assign unused_wbits = ^bus_wdata;

    always_comb begin
        st_d   = st_q;
        reload = '0;
        for (int p = 0; p < int'(NUM_FILT); p++) begin
            if (word_sel == WORD_W'(p / 4)) begin
                if (wr_set) begin
                    st_d.cfg[p].en  = st_q.cfg[p].en  | bus_wdata[8*(p%4)];
                    st_d.cfg[p].sel = st_q.cfg[p].sel | bus_wdata[8*(p%4)+4 +: 4];
                    reload[p]       = bus_wdata[8*(p%4)+1];
                end else if (wr_clr) begin
                    st_d.cfg[p].en  = st_q.cfg[p].en  & ~bus_wdata[8*(p%4)];
                    st_d.cfg[p].sel = st_q.cfg[p].sel & ~bus_wdata[8*(p%4)+4 +: 4];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_view) begin
            for (int p = 0; p < int'(NUM_FILT); p++) begin
                if (word_sel == WORD_W'(p / 4))
                    rdata[8*(p%4) +: 8] = {st_q.cfg[p].sel, 3'b000, st_q.cfg[p].en};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = rdata;
    assign cfg_o     = st_q.cfg;
    assign reload_o  = reload;

    // R2: a write to the read-only view leaves every stored field unchanged
    p_view_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[11:8] == REGION_VIEW) |=> $stable(st_q));

endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter
    import dbf_pkg::*;
#(
    parameter int unsigned SCALE_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_lvl,
    input  logic             level_mode,
    input  pin_cfg_t         cfg,
    input  logic             reload,
    output logic             filt_out
);

    localparam int unsigned MAX_TICKS = LONGEST_UNITS >> SCALE_SHIFT;
    localparam int unsigned CNT_W     = (MAX_TICKS > 1) ? $clog2(MAX_TICKS + 1) : 1;

    typedef struct packed {
        logic             out;
        logic [CNT_W-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [31:0] period_ticks;
    logic        active;

    assign period_ticks = period_units(cfg.sel) >> SCALE_SHIFT;
    assign active       = cfg.en && level_mode && (period_ticks != 32'd0);

    always_comb begin
        st_d = st_q;
        if (reload || !active) begin
            st_d.out = sync_lvl;
            st_d.cnt = '0;
        end else if (sync_lvl == st_q.out) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if ((32'(st_q.cnt) + 32'd1) >= period_ticks) begin
                st_d.out = sync_lvl;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_out = active ? st_q.out : sync_lvl;

    // R6: an active filter moves its output only on a prescaler tick
    p_move_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !reload && !tick) |=> $stable(st_q.out));

    // R7: an input matching the output keeps the count at zero
    p_match_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl == st_q.out) |=> (st_q.cnt == '0));

    // R8: a reload clears the counter and copies the input at the same edge
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.cnt == '0 && st_q.out == $past(sync_lvl)));

    // R4: an idle filter keeps tracking its input
    p_idle_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (st_q.out == $past(sync_lvl)));

endmodule

// File: rtl/pin_debounce_bank.sv
module pin_debounce_bank
    import dbf_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned NUM_FILT    = 6,
    parameter int unsigned TICK_DIV    = 2,
    parameter int unsigned SCALE_SHIFT = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [11:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] pin_level_mode,
    output logic [NUM_PINS-1:0] pin_filt
);

    typedef struct packed {
        logic [NUM_PINS-1:0] s1;
        logic [NUM_PINS-1:0] s2;
    } sync_state_t;

    sync_state_t             sync_d, sync_q;
    logic                    tick;
    pin_cfg_t [NUM_FILT-1:0] cfg;
    logic [NUM_FILT-1:0]     reload;
    logic                    unused_modes;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_raw;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    dbf_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    dbf_ctrl_regs #(.NUM_FILT(NUM_FILT)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg),
        .reload_o  (reload)
    );

    assign unused_modes = ^pin_level_mode;

    generate
        for (genvar p = 0; p < int'(NUM_PINS); p++) begin : g_pin
            if (p < int'(NUM_FILT)) begin : g_filt
                dbf_pin_filter #(.SCALE_SHIFT(SCALE_SHIFT)) filt_i (
                    .clk        (clk),
                    .rst_n      (rst_n),
                    .tick       (tick),
                    .sync_lvl   (sync_q.s2[p]),
                    .level_mode (pin_level_mode[p]),
                    .cfg        (cfg[p]),
                    .reload     (reload[p]),
                    .filt_out   (pin_filt[p])
                );
            end else begin : g_pass
                assign pin_filt[p] = sync_q.s2[p];

                // R3: unfiltered pins show the first stage one edge later
                p_unfiltered_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (pin_filt[p] == $past(sync_q.s1[p])));
            end
        end
    endgenerate

endmodule

// File: tb/pin_debounce_bank_tb.sv
`timescale 1ns/1ps
module pin_debounce_bank_tb_top;

    localparam int NP = 8;
    localparam int TD = 2;

    typedef struct packed {
        logic [3:0]  pin;
        logic [3:0]  sel;
        logic [15:0] ticks;
    } vec_t;

    // Period ticks = units >> 7 (R5), one vector per table entry plus a saturating select.
    localparam vec_t VECS [8] = '{
        '{pin: 4'd0, sel: 4'd0, ticks: 16'd3},
        '{pin: 4'd1, sel: 4'd1, ticks: 16'd7},
        '{pin: 4'd2, sel: 4'd2, ticks: 16'd125},
        '{pin: 4'd3, sel: 4'd3, ticks: 16'd250},
        '{pin: 4'd4, sel: 4'd4, ticks: 16'd500},
        '{pin: 4'd5, sel: 4'd5, ticks: 16'd1000},
        '{pin: 4'd0, sel: 4'd6, ticks: 16'd2000},
        '{pin: 4'd1, sel: 4'd9, ticks: 16'd2000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_mode = '1;
    logic [NP-1:0] pin_filt;

    logic          b2_we = 1'b0;
    logic [11:0]   b2_addr = '0;
    logic [31:0]   b2_wdata = '0;
    logic [31:0]   b2_rdata;
    logic [NP-1:0] raw2 = '0;
    logic [NP-1:0] filt2;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pin_debounce_bank #(.NUM_PINS(NP), .NUM_FILT(6), .TICK_DIV(TD), .SCALE_SHIFT(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_raw(pin_raw),
        .pin_level_mode(pin_mode), .pin_filt(pin_filt)
    );

    pin_debounce_bank #(.NUM_PINS(NP), .NUM_FILT(6), .TICK_DIV(TD), .SCALE_SHIFT(9)) dut2_i (
        .clk(clk), .rst_n(rst_n), .bus_we(b2_we), .bus_addr(b2_addr),
        .bus_wdata(b2_wdata), .bus_rdata(b2_rdata), .pin_raw(raw2),
        .pin_level_mode(pin_mode), .pin_filt(filt2)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr2(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        b2_we = 1'b1; b2_addr = a; b2_wdata = d;
        @(negedge clk);
        b2_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Clear the byte, then set enable, select and the reload bit.
    task automatic setup_pin(input int pin, input logic [3:0] sel, input bit en);
        logic [11:0] off;
        off = 12'(4 * (pin / 4));
        wr(12'h700 + off, 32'hFF << (8 * (pin % 4)));
        wr(12'h600 + off, 32'({sel, 2'b00, 1'b1, en}) << (8 * (pin % 4)));
    endtask

    // Count clock edges from a raw change (made at a negedge) until the output shows target.
    task automatic measure(input int pin, input logic target, input bit second, output int n);
        n = 0;
        for (int i = 0; i < 6000; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if ((second ? filt2[pin] : pin_filt[pin]) == target) break;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int n, lo, hi, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: reset state
        rd(12'h500, d); check(d == 0, "R10 word0", int'(d), 0);
        rd(12'h504, d); check(d == 0, "R10 word1", int'(d), 0);
        check(pin_filt == 0, "R10 outputs", int'(pin_filt), 0);

        // Table walk: R1, R5, R6, R8
        foreach (VECS[k]) begin
            int pin;
            pin = int'(VECS[k].pin);
            setup_pin(pin, VECS[k].sel, 1'b1);
            rd(12'h500 + 12'(4 * (pin / 4)), d);
            check(d[8*(pin%4) +: 8] == {VECS[k].sel, 4'b0001}, "R1 R8 byte readback",
                  int'(d[8*(pin%4) +: 8]), int'({VECS[k].sel, 4'b0001}));
            lo = (int'(VECS[k].ticks) - 1) * TD + 3;
            hi = int'(VECS[k].ticks) * TD + 2;
            @(negedge clk); pin_raw[pin] = 1'b1;
            measure(pin, 1'b1, 1'b0, n);
            check(n >= lo && n <= hi, "R5 R6 rise latency", n, hi);
            @(negedge clk); pin_raw[pin] = 1'b0;
            measure(pin, 1'b0, 1'b0, n);
            check(n >= lo && n <= hi, "R6 fall latency", n, hi);
            wr(12'h700 + 12'(4 * (pin / 4)), 32'hFF << (8 * (pin % 4)));
        end

        // R1: an unaligned or out-of-window address reads 0
        setup_pin(0, 4'd2, 1'b1);
        rd(12'h501, d); check(d == 0, "R1 unaligned read", int'(d), 0);
        rd(12'h600, d); check(d == 0, "R1 set window read", int'(d), 0);

        // R2: view window ignores writes; clear removes only written bits
        wr(12'h500, 32'hFFFF_FFFF);
        rd(12'h500, d); check(d[31:8] == 0 && d[7:0] == 8'h21, "R2 view write", int'(d), 32'h21);
        wr(12'h700, 32'h0000_0001);
        rd(12'h500, d); check(d[7:0] == 8'h20, "R2 clear enable only", int'(d[7:0]), 32'h20);
        wr(12'h600, 32'h0000_0040);
        rd(12'h500, d); check(d[7:0] == 8'h60, "R2 set ors select", int'(d[7:0]), 32'h60);
        wr(12'h700, 32'h0000_00FF);

        // R3: pin 6 has no filter
        wr(12'h604, 32'h00FF_0000);
        rd(12'h504, d); check(d[23:16] == 0, "R3 unfiltered byte", int'(d[23:16]), 0);
        @(negedge clk); pin_raw[6] = 1'b1;
        measure(6, 1'b1, 1'b0, n);
        check(n == 2, "R3 unfiltered latency", n, 2);
        @(negedge clk); pin_raw[6] = 1'b0;

        // R4: enabled but edge-sensitive, then level-sensitive but disabled
        setup_pin(0, 4'd2, 1'b1);
        pin_mode[0] = 1'b0;
        @(negedge clk); pin_raw[0] = 1'b1;
        measure(0, 1'b1, 1'b0, n);
        check(n == 2, "R4 edge mode latency", n, 2);
        pin_mode[0] = 1'b1;
        setup_pin(0, 4'd2, 1'b0);
        @(negedge clk); pin_raw[0] = 1'b0;
        measure(0, 1'b0, 1'b0, n);
        check(n == 2, "R4 disabled latency", n, 2);

        // R7: short pulse rejected, then a dip restarts the count
        setup_pin(2, 4'd2, 1'b1);
        bad = 0;
        @(negedge clk); pin_raw[2] = 1'b1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (pin_filt[2]) bad++; end
        pin_raw[2] = 1'b0;
        for (int i = 0; i < 350; i++) begin @(negedge clk); if (pin_filt[2]) bad++; end
        check(bad == 0, "R7 pulse rejected", bad, 0);
        pin_raw[2] = 1'b1;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (pin_filt[2]) bad++; end
        pin_raw[2] = 1'b0;
        @(negedge clk); pin_raw[2] = 1'b1;
        measure(2, 1'b1, 1'b0, n);
        check(bad == 0, "R7 held early output", bad, 0);
        check(n >= 251 && n <= 252, "R7 restart latency", n, 252);

        // R8: reload copies the input at once
        setup_pin(3, 4'd3, 1'b1);
        @(negedge clk); pin_raw[3] = 1'b1;
        repeat (50) @(negedge clk);
        check(pin_filt[3] == 1'b0, "R8 before reload", int'(pin_filt[3]), 0);
        wr(12'h600, 32'h0200_0000);
        check(pin_filt[3] == 1'b1, "R8 reload output", int'(pin_filt[3]), 1);
        rd(12'h500, d); check(d[25] == 1'b0, "R8 reload bit reads 0", int'(d[25]), 0);

        // R9: shift 9 makes select 0 zero ticks (pass-through), select 1 one tick
        wr2(12'h600, 32'h0000_0003);
        @(negedge clk); raw2[0] = 1'b1;
        measure(0, 1'b1, 1'b1, n);
        check(n == 2, "R9 zero period passes", n, 2);
        wr2(12'h600, 32'h0000_0013);
        @(negedge clk); raw2[0] = 1'b0;
        measure(0, 1'b0, 1'b1, n);
        check(n >= 3 && n <= 4, "R9 one tick period", n, 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule